// File: doc/BRIEF.md
# Programmable Processor Watchdog Timer

This block watches for a processor that has stopped servicing it. Software programs one 8-bit control register over a simple strobe bus. The register sets a timeout period and picks one of two reactions. Any read or write of that register starts the period again. When the period runs out with no access, the block does one of two things, chosen by a steering bit. It either raises a sticky flag and pulls a shared active-low interrupt line low, or it drives an active-low processor reset pulse of fixed length. In the reset case the block also disarms itself.

All timing is measured in periods of an externally supplied 1/16-second tick enable. The interrupt line is shared with a frequency-test waveform that software can switch on. While the watchdog is armed in interrupt mode, the watchdog owns that line and the waveform is kept off it.

Top module: `wdog_ctrl`

## Requirements
- R1: After the synchronous reset, the control register and the frequency-test enable are zero, the flag is clear, `irq_ftest_n` and `cpu_rst_n` are high, and the watchdog is disarmed.
- R2: The control register (address 0) holds the steering bit in bit 7, a 5-bit multiplier in bits 6:2 and a resolution code in bits 1:0. Codes 0, 1, 2 and 3 give 1, 4, 16 and 64 ticks per unit. A timeout happens on the tick that completes multiplier × ticks-per-unit ticks after the last restart.
- R3: Any read or write of the control register clears the elapsed count, so a full period must elapse again before a timeout.
- R4: A multiplier of zero disarms the watchdog whatever the resolution code (8'h00 included), and no timeout ever fires.
- R5: On a timeout with steering bit 0, the flag sets and `irq_ftest_n` goes low. Both stay that way until the status register is read or the control register is read or written.
- R6: On a timeout with steering bit 1, `cpu_rst_n` goes low for RST_TICKS ticks (default 2, that is 125 ms). At the same time the control register and the frequency-test enable clear to zero, and the flag is not set.
- R7: While the reset pulse is active, the timeout count does not advance on ticks.
- R8: The status register (address 1) shows the flag in bit 7. Reading it returns the flag and clears the flag and the interrupt.
- R9: Status bit 0 is the frequency-test enable, written through status bit 0. When it is set and the watchdog is not armed in interrupt mode, `irq_ftest_n` follows `ftest_wave` one clock later. When the watchdog is armed with steering bit 0, the waveform is blocked and the line stays high unless the flag is set.
- R10: A read strobe on either address returns that register's value on `bus_rdata` on the clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable every 1/16 second |
| bus_cs | input | 1 | Register select |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 1 | 0 = control register, 1 = status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ftest_wave | input | 1 | Frequency-test waveform |
| irq_ftest_n | output | 1 | Shared active-low interrupt / frequency-test output |
| cpu_rst_n | output | 1 | Active-low processor reset pulse |

## Verification
Several rules are checked by the assertions on every cycle. The elapsed count stays below the programmed terminal. A control access or a disarmed register never gives an expiry on the next cycle. An expiry sets the flag or starts the reset pulse on the next edge. The flag always drives the interrupt low, an armed interrupt-mode watchdog keeps the test waveform off the line, the count freezes during the pulse, and a reset-mode expiry clears the control register. Some things only the directed scenarios can show: the exact period for each resolution code, a restart partway through a period, the length of the reset pulse in ticks, and the values software reads back.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int MULT_W   = 5;
  localparam int RES_W    = 2;
  localparam int REG_W    = 1 + MULT_W + RES_W;
  // largest terminal: multiplier scaled by 4**(2**RES_W - 1)
  localparam int TERM_W   = MULT_W + 2 * ((2 ** RES_W) - 1);

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int   STAT_FLAG_BIT = 7;
  localparam int   STAT_FT_BIT   = 0;

  typedef struct packed {
    logic              steer;  // 0: interrupt, 1: reset pulse
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;    // ticks per unit = 4**res
  } wd_ctrl_t;

  function automatic logic [TERM_W-1:0] term_of(input wd_ctrl_t c);
    return TERM_W'(c.mult) << (2 * c.res);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cs,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             expire_rst,
  input  logic             flag,
  output wd_ctrl_t         ctrl,
  output logic             ft_en,
  output logic             ctrl_access,
  output logic             stat_rd,
  output logic [REG_W-1:0] bus_rdata
);

  logic             wr_ctrl, wr_stat;
  logic [REG_W-1:0] stat_word;

  assign wr_ctrl     = bus_cs && bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_stat     = bus_cs && bus_wr && (bus_addr == ADDR_STAT);
  assign ctrl_access = bus_cs && (bus_rd || bus_wr) && (bus_addr == ADDR_CTRL);
  assign stat_rd     = bus_cs && bus_rd && (bus_addr == ADDR_STAT);

  always_comb begin
    stat_word                = '0;
    stat_word[STAT_FLAG_BIT] = flag;
    stat_word[STAT_FT_BIT]   = ft_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      ft_en     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (expire_rst) begin
        ctrl  <= '0;
        ft_en <= 1'b0;
      end else begin
        if (wr_ctrl) ctrl  <= wd_ctrl_t'(bus_wdata);
        if (wr_stat) ft_en <= bus_wdata[STAT_FT_BIT];
      end
      if (bus_cs && bus_rd)
        bus_rdata <= (bus_addr == ADDR_CTRL) ? REG_W'(ctrl) : stat_word;
    end
  end

  a_r6_clear_on_reset_timeout: assert property (@(posedge clk) disable iff (rst)
    expire_rst |=> (ctrl == '0) && !ft_en);

  a_r10_ctrl_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !expire_rst) |=> (REG_W'(ctrl) == $past(bus_wdata)));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W = TERM_W
)(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  wd_ctrl_t ctrl,
  input  logic     restart,
  input  logic     hold,
  output logic     armed,
  output logic     expire_irq,
  output logic     expire_rst
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;

  assign armed = (ctrl.mult != '0);
  assign term  = CNT_W'(term_of(ctrl));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      expire_irq <= 1'b0;
      expire_rst <= 1'b0;
    end else begin
      expire_irq <= 1'b0;
      expire_rst <= 1'b0;
      if (restart || !armed) begin
        cnt <= '0;
      end else if (tick && !hold) begin
        if (cnt == term - 1'b1) begin
          cnt        <= '0;
          expire_irq <= !ctrl.steer;
          expire_rst <= ctrl.steer;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r2_count_below_terminal: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt < term));

  a_r3_restart_no_expiry: assert property (@(posedge clk) disable iff (rst)
    restart |=> !(expire_irq || expire_rst));

  a_r4_disarmed_no_expiry: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !(expire_irq || expire_rst));

  a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (hold && armed && !restart) |=> $stable(cnt));

endmodule

// File: rtl/wdog_out.sv
module wdog_out #(
  parameter int RST_TICKS = 2
)(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic expire_irq,
  input  logic expire_rst,
  input  logic flag_clr,
  input  logic ft_en,
  input  logic ftest_wave,
  input  logic armed,
  input  logic steer,
  output logic flag,
  output logic pulse_on,
  output logic irq_ftest_n,
  output logic cpu_rst_n
);

  localparam int PULSE_W = $clog2(RST_TICKS + 1);

  logic [PULSE_W-1:0] pcnt;
  logic               ft_pass;
  logic               irq_d;

  assign pulse_on = (pcnt != '0);
  assign ft_pass  = ft_en && !(armed && !steer);

  always_comb begin
    if (flag)         irq_d = 1'b0;
    else if (ft_pass) irq_d = ftest_wave;
    else              irq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag        <= 1'b0;
      pcnt        <= '0;
      cpu_rst_n   <= 1'b1;
      irq_ftest_n <= 1'b1;
    end else begin
      if (expire_irq)    flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;

      if (expire_rst) begin
        pcnt      <= PULSE_W'(RST_TICKS);
        cpu_rst_n <= 1'b0;
      end else if (pulse_on && tick) begin
        pcnt <= pcnt - 1'b1;
        if (pcnt == PULSE_W'(1)) cpu_rst_n <= 1'b1;
      end

      irq_ftest_n <= irq_d;
    end
  end

  a_r5_flag_on_timeout: assert property (@(posedge clk) disable iff (rst)
    expire_irq |=> flag);

  a_r5_flag_drives_irq: assert property (@(posedge clk) disable iff (rst)
    flag |=> !irq_ftest_n);

  a_r8_flag_cleared: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !expire_irq) |=> !flag);

  a_r6_pulse_starts: assert property (@(posedge clk) disable iff (rst)
    expire_rst |=> !cpu_rst_n);

  a_r9_wave_blocked: assert property (@(posedge clk) disable iff (rst)
    (!flag && armed && !steer) |=> irq_ftest_n);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int RST_TICKS = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16,
  input  logic             bus_cs,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ftest_wave,
  output logic             irq_ftest_n,
  output logic             cpu_rst_n
);

  wd_ctrl_t ctrl;
  logic     ft_en, ctrl_access, stat_rd;
  logic     armed, expire_irq, expire_rst;
  logic     flag, pulse_on;

  wdog_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_cs      (bus_cs),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .expire_rst  (expire_rst),
    .flag        (flag),
    .ctrl        (ctrl),
    .ft_en       (ft_en),
    .ctrl_access (ctrl_access),
    .stat_rd     (stat_rd),
    .bus_rdata   (bus_rdata)
  );

  wdog_timer #(.CNT_W(TERM_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick16),
    .ctrl       (ctrl),
    .restart    (ctrl_access),
    .hold       (pulse_on),
    .armed      (armed),
    .expire_irq (expire_irq),
    .expire_rst (expire_rst)
  );

  wdog_out #(.RST_TICKS(RST_TICKS)) u_out (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick16),
    .expire_irq  (expire_irq),
    .expire_rst  (expire_rst),
    .flag_clr    (stat_rd || ctrl_access),
    .ft_en       (ft_en),
    .ftest_wave  (ftest_wave),
    .armed       (armed),
    .steer       (ctrl.steer),
    .flag        (flag),
    .pulse_on    (pulse_on),
    .irq_ftest_n (irq_ftest_n),
    .cpu_rst_n   (cpu_rst_n)
  );

endmodule

// File: tb/wdog_ctrl_tb.sv
module wdog_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ftest_wave = 1'b1;
  logic       irq_ftest_n, cpu_rst_n;

  int checks = 0;
  int errors = 0;
  int tdiv   = 0;

  always #5 clk = ~clk;

  // one-cycle tick every 8 clocks, changed away from the active edge
  always @(negedge clk) begin
    tdiv   = (tdiv + 1) % 8;
    tick16 = (tdiv == 0);
  end

  wdog_ctrl #(.RST_TICKS(2)) u_dut (
    .clk(clk), .rst(rst), .tick16(tick16),
    .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ftest_wave(ftest_wave), .irq_ftest_n(irq_ftest_n), .cpu_rst_n(cpu_rst_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_cs = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!tick16) @(posedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
    settle();
  endtask

  // expects irq high after term-1 ticks and low after term ticks
  task automatic period_case(input logic [7:0] cfg, input int term, input string req);
    logic [7:0] d;
    bus_write(1'b0, cfg);
    if (term > 1) begin
      wait_ticks(term - 1);
      chk({req, " no early timeout"}, {7'b0, irq_ftest_n}, 8'h01);
      wait_ticks(1);
    end else begin
      wait_ticks(1);
    end
    chk({req, " timeout on terminal tick"}, {7'b0, irq_ftest_n}, 8'h00);
    bus_read(1'b1, d);
    chk("R8 status shows flag", d, 8'h80);
    @(negedge clk);
    chk("R8 status read releases irq", {7'b0, irq_ftest_n}, 8'h01);
    bus_write(1'b0, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq idle", {7'b0, irq_ftest_n}, 8'h01);
    chk("R1 reset idle", {7'b0, cpu_rst_n}, 8'h01);
    bus_read(1'b0, d);
    chk("R1 ctrl zero", d, 8'h00);
    bus_read(1'b1, d);
    chk("R1 status zero", d, 8'h00);
  endtask

  task automatic t_periods();
    period_case(8'h0C, 3,  "R2 mult3 res0");
    period_case(8'h09, 8,  "R2 mult2 res1");
    period_case(8'h06, 16, "R2 mult1 res2");
    period_case(8'h07, 64, "R2 mult1 res3");
  endtask

  task automatic t_restart();
    logic [7:0] d;
    bus_write(1'b0, 8'h0C);
    wait_ticks(2);
    bus_read(1'b0, d);
    chk("R10 ctrl read back", d, 8'h0C);
    wait_ticks(2);
    chk("R3 read restarted count", {7'b0, irq_ftest_n}, 8'h01);
    wait_ticks(1);
    chk("R3 timeout after full period", {7'b0, irq_ftest_n}, 8'h00);
    bus_write(1'b0, 8'h00);
    @(negedge clk);
    chk("R5 ctrl write releases irq", {7'b0, irq_ftest_n}, 8'h01);
    bus_write(1'b0, 8'h0C);
    wait_ticks(3);
    chk("R5 irq held", {7'b0, irq_ftest_n}, 8'h00);
    wait_ticks(1);
    chk("R5 irq stays low", {7'b0, irq_ftest_n}, 8'h00);
    bus_read(1'b0, d);
    @(negedge clk);
    chk("R5 ctrl read releases irq", {7'b0, irq_ftest_n}, 8'h01);
    bus_write(1'b0, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    bus_write(1'b0, 8'h03);
    wait_ticks(70);
    chk("R4 zero multiplier never fires", {7'b0, irq_ftest_n}, 8'h01);
    bus_read(1'b1, d);
    chk("R4 flag stays clear", d, 8'h00);
    bus_write(1'b0, 8'h00);
    wait_ticks(5);
    chk("R4 00h disarmed", {7'b0, irq_ftest_n}, 8'h01);
  endtask

  task automatic t_reset_pulse();
    logic [7:0] d;
    bus_write(1'b1, 8'h01);
    bus_write(1'b0, 8'h88);
    wait_ticks(1);
    chk("R6 no pulse before terminal", {7'b0, cpu_rst_n}, 8'h01);
    wait_ticks(1);
    chk("R6 pulse starts", {7'b0, cpu_rst_n}, 8'h00);
    bus_read(1'b0, d);
    chk("R6 ctrl cleared", d, 8'h00);
    bus_write(1'b0, 8'h04);
    wait_ticks(1);
    chk("R6 pulse still low", {7'b0, cpu_rst_n}, 8'h00);
    wait_ticks(1);
    chk("R6 pulse ends", {7'b0, cpu_rst_n}, 8'h01);
    chk("R7 count held during pulse", {7'b0, irq_ftest_n}, 8'h01);
    wait_ticks(1);
    chk("R7 count resumes", {7'b0, irq_ftest_n}, 8'h00);
    bus_read(1'b1, d);
    chk("R6 ftest enable cleared", d, 8'h80);
    bus_write(1'b0, 8'h00);
  endtask

  task automatic t_ftest();
    logic [7:0] d;
    bus_write(1'b1, 8'h01);
    bus_read(1'b1, d);
    chk("R9 enable in status bit0", d, 8'h01);
    ftest_wave = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 wave low passes", {7'b0, irq_ftest_n}, 8'h00);
    ftest_wave = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 wave high passes", {7'b0, irq_ftest_n}, 8'h01);
    bus_write(1'b0, 8'h7C);
    ftest_wave = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 wave blocked in interrupt mode", {7'b0, irq_ftest_n}, 8'h01);
    bus_write(1'b0, 8'hFC);
    repeat (2) @(negedge clk);
    chk("R9 wave passes in reset mode", {7'b0, irq_ftest_n}, 8'h00);
    bus_write(1'b0, 8'h00);
    bus_write(1'b1, 8'h00);
    repeat (2) @(negedge clk);
    chk("R9 disabled wave ignored", {7'b0, irq_ftest_n}, 8'h01);
    ftest_wave = 1'b1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_periods();
    t_restart();
    t_disabled();
    t_reset_pulse();
    t_ftest();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule